// File: doc/BRIEF.md
# Bidirectional Modulo-5 Ring Counter with Binary Readout

This block counts through five states, holding its position as a five-bit vector in which exactly one flip-flop is set. On every rising clock edge a single direction pin decides whether the hot bit moves one place toward the top of the vector or one place toward the bottom. At either end the bit wraps around to the opposite end, so the sequence is 0,1,2,3,4,0 going up and 0,4,3,2,1,0 going down.

Alongside the raw vector, an OR-based encoder forms a three-bit unsigned count equal to the position of the hot bit. That count is suitable for feeding a display decoder directly. The direction and reset pins are plain control pins. There is no data stream, so no handshake applies.

A synchronous reset puts the counter in position 0. If the vector is ever found holding zero or several set bits, the next edge also returns it to position 0.

Top module: `onehot_mod5_counter`

## Requirements
- R1: While `rst` is 1 at a rising edge, the next outputs are `hot_q` = 5'b00001 and `count_q` = 3'd0, regardless of `up_dn`.
- R2: After the first reset, `hot_q` has exactly one bit set after every rising edge.
- R3: With `rst` = 0 and `up_dn` = 1 at an edge, the position increases by one, and position 4 goes to position 0.
- R4: With `rst` = 0 and `up_dn` = 0 at an edge, the position decreases by one, and position 0 goes to position 4.
- R5: `count_q` is the unsigned binary index (0 to 4, bit 2 most significant) of the set bit of `hot_q`. It follows `hot_q` with no extra clock of delay.
- R6: `up_dn` is sampled separately at each edge, so reversing direction between two consecutive edges reverses the very next step with no lost or extra step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| hot_q | output | 5 | One-hot position; bit i set means position i |
| count_q | output | 3 | Binary index of the set bit of `hot_q` |

## Verification
The assertions assume that `rst` is high at the first rising edge, so the vector is defined before any property is armed. They also assume that `up_dn` holds a known 0 or 1 at every edge. The stimulus holds reset from time zero and changes `rst` and `up_dn` only on falling clock edges, always to defined values. Directed runs cross both wrap points, and a random walk with reversals and occasional mid-run resets covers the rest of the state space.

// File: rtl/ring5_pkg.sv
package ring5_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ring5_next.sv
module ring5_next #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] cur,
  input  logic         dir_up,
  output logic [N-1:0] nxt
);
  localparam logic [N-1:0] HOME = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] up_v;
  logic [N-1:0] dn_v;
  logic         legal;

  // Each bit copies one neighbour: the one below going up, the one above going down.
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign up_v[i] = cur[(i + N - 1) % N];
    assign dn_v[i] = cur[(i + 1) % N];
  end

  always_comb begin
    int unsigned ones;
    ones = 0;
    for (int i = 0; i < N; i++) ones += int'(cur[i]);
    legal = (ones == 1);
  end

  always_comb begin
    if (!legal)      nxt = HOME;
    else if (dir_up) nxt = up_v;
    else             nxt = dn_v;
  end
endmodule

// File: rtl/ring5_encode.sv
module ring5_encode #(
  parameter int unsigned N  = 5,
  parameter int unsigned CW = 3
) (
  input  logic [N-1:0]  oh,
  output logic [CW-1:0] bin
);
  // OR of the indices of set bits; exact whenever one bit is set.
  always_comb begin
    bin = '0;
    for (int i = 0; i < N; i++) begin
      if (oh[i]) bin = bin | CW'(i);
    end
  end
endmodule

// File: rtl/onehot_mod5_counter.sv
module onehot_mod5_counter
  import ring5_pkg::*;
#(
  parameter int unsigned N  = 5,
  parameter int unsigned CW = idx_width(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_dn,
  output logic [N-1:0]  hot_q,
  output logic [CW-1:0] count_q
);
  localparam logic [N-1:0]  HOME = {{(N-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] TOP  = CW'(N - 1);

  logic [N-1:0] state_q;
  logic [N-1:0] state_d;

  ring5_next #(.N(N)) u_next (
    .cur    (state_q),
    .dir_up (up_dn == DIR_UP),
    .nxt    (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= HOME;
    else     state_q <= state_d;
  end

  ring5_encode #(.N(N), .CW(CW)) u_enc (
    .oh  (state_q),
    .bin (count_q)
  );

  assign hot_q = state_q;

  a_r1_reset_home: assert property (@(posedge clk)
    rst |=> (hot_q == HOME && count_q == '0));

  a_r2_single_hot: assert property (@(posedge clk) disable iff (rst)
    $countones(hot_q) == 1);

  a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
    up_dn |=> count_q == (($past(count_q) == TOP) ? '0 : $past(count_q) + 1'b1));

  a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
    !up_dn |=> count_q == (($past(count_q) == '0) ? TOP : $past(count_q) - 1'b1));

  a_r5_index_matches: assert property (@(posedge clk) disable iff (rst)
    (int'(count_q) < N) && hot_q[count_q]);
endmodule

// File: tb/tb_onehot_mod5_counter.sv
module tb_onehot_mod5_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up_dn = 1'b0;
  logic [4:0] hot_q;
  logic [2:0] count_q;

  int checks = 0;
  int failures = 0;
  int model = 0;

  onehot_mod5_counter dut (
    .clk     (clk),
    .rst     (rst),
    .up_dn   (up_dn),
    .hot_q   (hot_q),
    .count_q (count_q)
  );

  always #10 clk = ~clk;

  task automatic check(input string req);
    int hot_idx;
    checks++;
    if (hot_q !== 5'(1 << model) || count_q !== 3'(model)) begin
      failures++;
      $display("FAIL %s: hot=%b count=%0d expected hot=%b count=%0d",
               req, hot_q, count_q, 5'(1 << model), model);
    end
    checks++;
    if ($countones(hot_q) != 1) begin
      failures++;
      $display("FAIL R2: hot=%b has %0d set bits, expected 1", hot_q, $countones(hot_q));
    end
    hot_idx = -1;
    for (int i = 0; i < 5; i++) if (hot_q[i] === 1'b1) hot_idx = i;
    checks++;
    if (hot_idx != int'(count_q)) begin
      failures++;
      $display("FAIL R5: count=%0d expected %0d (hot=%b)", count_q, hot_idx, hot_q);
    end
  endtask

  task automatic step(input bit r, input bit d, input string req);
    rst = r;
    up_dn = d;
    @(posedge clk);
    if (r)      model = 0;
    else if (d) model = (model + 1) % 5;
    else        model = (model + 4) % 5;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, "R1");
    for (int k = 0; k < 7; k++) step(1'b0, 1'b1, "R3");
    for (int k = 0; k < 9; k++) step(1'b0, 1'b0, "R4");
    step(1'b1, 1'b1, "R1");
    step(1'b0, 1'b0, "R4");
    step(1'b0, 1'b1, "R6");
    step(1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, "R6");
    step(1'b0, 1'b1, "R6");
    step(1'b0, 1'b1, "R6");
    for (int k = 0; k < 400; k++) begin
      bit r;
      bit d;
      r = ($urandom_range(0, 39) == 0);
      d = $urandom_range(0, 1) == 1;
      step(r, d, r ? "R1" : (d ? "R3" : "R4"));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule